// File: doc/BRIEF.md
# MSI Snooping Cache Coherence Controller

This block is the coherence engine of one processor's private cache on a shared broadcast bus. The cache is small and direct-mapped, one data word per line, and each line carries one of three coherence states: Invalid, Shared or Modified. Processor loads and stores are served locally when the line's state allows it. Otherwise the controller requests the bus and issues a read, which asks for a copy it will not modify, or a read-exclusive, which asks for a copy it will modify. There is no upgrade transaction, so a store to a Shared line always issues a full read-exclusive.

The controller also watches every transaction that other caches place on the bus. These transactions arrive in one global order that every cache sees in the same way. A foreign read that hits a dirty line makes the cache supply the data and keep a Shared copy. A foreign read-exclusive removes the local copy, and the data is supplied first if the line was dirty. The bus is atomic. Once the controller holds a grant, no other transaction is seen until its data returns. A dirty line that must make room for a new address is written back in a transaction of its own before the new request goes out.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high, `bus_req`, `cpu_resp` and `snp_flush` are low and `bus_cmd_o` is 0, so the first access to any address is a miss.
- R2: A processor read to a line that is Invalid, or that holds another tag, issues one bus read (`bus_cmd_o` = 1) at the request address. The word returned on `bus_rdata` becomes a Shared copy and is returned on `cpu_rdata`.
- R3: A processor read to a Shared or Modified line with a matching tag returns the stored word with no bus request, and the line's state does not change.
- R4: A processor write to an Invalid or Shared line issues one bus read-exclusive (`bus_cmd_o` = 2) and leaves the line Modified, holding the written word. A write to a Modified line completes with no bus request.
- R5: A foreign bus read (`bus_cmd` = 1) that hits a Modified line raises `snp_flush` with the line's word on `snp_data` in the cycle after the address cycle, and the line becomes Shared.
- R6: A foreign bus read that hits a Shared line causes no flush and leaves the line Shared.
- R7: A foreign read-exclusive (`bus_cmd` = 2) that hits a Modified line flushes its word and invalidates the line. One that hits a Shared line invalidates it without a flush.
- R8: A bus cycle whose `bus_owner` equals the cache's own identifier is never snooped. It causes no flush and no state change.
- R9: A miss whose line holds a Modified copy of another address first issues a write-back (`bus_cmd_o` = 3), carrying that address and the dirty word on `bus_wdata_o`, and then issues the new request. A Shared victim is dropped with no bus traffic.
- R10: `cpu_ready` is low from the cycle after a request is accepted until its response. `cpu_resp` is a one-cycle pulse, one per request.
- R11: When a foreign transaction hits the index being looked up in the same cycle, the snoop takes effect first and the processor request is judged again against the new state.
- R12: `bus_req` stays high with a stable `bus_cmd_o` and `bus_addr_o` until `bus_gnt` is seen for a read or read-exclusive, and `bus_cmd_o` is 0 whenever `bus_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_write | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_resp | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result, or the stored word for a store |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Grant, high for the single address cycle |
| bus_cmd_o | output | 2 | Command driven as owner: 1 read, 2 read-exclusive, 3 write-back |
| bus_addr_o | output | ADDR_W | Address driven as owner |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_valid | input | 1 | Address cycle present on the shared bus |
| bus_cmd | input | 2 | Command on the shared bus |
| bus_addr | input | ADDR_W | Address on the shared bus |
| bus_owner | input | ID_W | Identifier of the current bus owner |
| bus_rvalid | input | 1 | Data return for the owner's read or read-exclusive |
| bus_rdata | input | DATA_W | Returned word, flushed data or memory |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_data | output | DATA_W | Flushed word |

## Verification
A processor lookup and a foreign snoop can land on the same line index in the same cycle. The bench provokes this by placing a foreign read-exclusive on the bus in the one cycle in which a store to a Modified line is being looked up. It then expects the old word to be flushed, and the store to turn into a miss that issues its own read-exclusive and completes with the new data. The bench also grants its own bus requests late to check that they are held, and sends a bus cycle carrying the cache's own identifier to check that it is ignored.

// File: rtl/msi_pkg.sv
// Package: shared encodings for the MSI cache controller.
// Assumes a 2-bit bus command field whose values are decoded by every cache on the bus.
package msi_pkg;

    // Coherence state of one cache line.
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_state_t;

    // Command carried on the shared bus.
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_t;

    // Processor-side controller phases.
    typedef enum logic [2:0] {
        F_IDLE   = 3'd0,
        F_LOOKUP = 3'd1,
        F_WBREQ  = 3'd2,
        F_BUSREQ = 3'd3,
        F_WAIT   = 3'd4
    } fsm_t;

endpackage

// File: rtl/msi_line_store.sv
// Module: direct-mapped line store with tag, state and one data word per line.
// Two read ports: one indexed by the processor side, one by the snooper.
// Two state write ports: the snooper updates state only, while the processor side
// writes tag and state and, separately, data. The controller guarantees that the two
// never target the same index in one cycle.
module msi_line_store
    import msi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int INDEX_W = $clog2(LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] p_idx,
    input  logic               p_we,
    input  logic [TAG_W-1:0]   p_tag,
    input  line_state_t        p_state,
    input  logic               p_dwe,
    input  logic [DATA_W-1:0]  p_data,
    output logic [TAG_W-1:0]   p_tag_q,
    output line_state_t        p_state_q,
    output logic [DATA_W-1:0]  p_data_q,
    input  logic [INDEX_W-1:0] s_idx,
    input  logic               s_we,
    input  line_state_t        s_state,
    output logic [TAG_W-1:0]   s_tag_q,
    output line_state_t        s_state_q,
    output logic [DATA_W-1:0]  s_data_q
);

    line_state_t       st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    // Array update: reset to Invalid, then apply snoop and processor writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= ST_I;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (s_we && s_idx == INDEX_W'(i)) st_q[i] <= s_state;
                if (p_we && p_idx == INDEX_W'(i)) begin
                    st_q[i]  <= p_state;
                    tag_q[i] <= p_tag;
                end
                if (p_dwe && p_idx == INDEX_W'(i)) dat_q[i] <= p_data;
            end
        end
    end

    // Processor-side read port.
    always_comb begin
        p_tag_q   = tag_q[p_idx];
        p_state_q = st_q[p_idx];
        p_data_q  = dat_q[p_idx];
    end

    // Snoop-side read port.
    always_comb begin
        s_tag_q   = tag_q[s_idx];
        s_state_q = st_q[s_idx];
        s_data_q  = dat_q[s_idx];
    end

endmodule

// File: rtl/msi_snoop_unit.sv
// Module: snooper. Decodes foreign read and read-exclusive cycles, updates the
// hit line's state in the same cycle and registers a flush response for the next one.
// Assumes the bus is atomic, so a foreign cycle never overlaps this cache's own
// grant or data return.
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int LINES    = 4,
    parameter int ID_W     = 2,
    parameter int CACHE_ID = 0,
    localparam int INDEX_W = $clog2(LINES),
    localparam int TAG_W   = ADDR_W - INDEX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic [1:0]         bus_cmd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [ID_W-1:0]    bus_owner,
    input  logic [TAG_W-1:0]   line_tag,
    input  line_state_t        line_state,
    input  logic [DATA_W-1:0]  line_data,
    output logic [INDEX_W-1:0] s_idx,
    output logic               s_we,
    output line_state_t        s_state,
    output logic               snoop_active,
    output logic               snp_flush,
    output logic [DATA_W-1:0]  snp_data
);

    logic hit;
    logic flush_d;

    assign s_idx = bus_addr[INDEX_W-1:0];

    // Foreign-transaction decode and next-state choice for the hit line.
    always_comb begin
        snoop_active = bus_valid && (bus_owner != ID_W'(CACHE_ID))
                       && (bus_cmd == CMD_RD || bus_cmd == CMD_RDX);
        hit     = snoop_active && (line_state != ST_I)
                  && (line_tag == bus_addr[ADDR_W-1:INDEX_W]);
        s_we    = 1'b0;
        s_state = line_state;
        flush_d = 1'b0;
        if (hit && line_state == ST_M) begin
            s_we    = 1'b1;
            s_state = (bus_cmd == CMD_RD) ? ST_S : ST_I;
            flush_d = 1'b1;
        end else if (hit && bus_cmd == CMD_RDX) begin
            s_we    = 1'b1;
            s_state = ST_I;
        end
    end

    // Flush response register, one cycle after the address cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snp_flush <= 1'b0;
            snp_data  <= '0;
        end else begin
            snp_flush <= flush_d;
            snp_data  <= flush_d ? line_data : '0;
        end
    end

endmodule

// File: rtl/msi_proc_fsm.sv
// Module: processor-side controller. Accepts one request at a time, looks it up,
// answers hits directly, and otherwise writes back a dirty victim before issuing
// a read or read-exclusive. Assumes at most one bus transaction outstanding and
// that a lookup colliding with a snoop on the same index is retried.
module msi_proc_fsm
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4,
    localparam int INDEX_W = $clog2(LINES),
    localparam int TAG_W   = ADDR_W - INDEX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_valid,
    input  logic               cpu_write,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_ready,
    output logic               cpu_resp,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [1:0]         bus_cmd_o,
    output logic [ADDR_W-1:0]  bus_addr_o,
    output logic [DATA_W-1:0]  bus_wdata_o,
    input  logic               bus_rvalid,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               snoop_active,
    input  logic [INDEX_W-1:0] snoop_idx,
    output logic [INDEX_W-1:0] p_idx,
    output logic               p_we,
    output logic [TAG_W-1:0]   p_tag,
    output line_state_t        p_state,
    output logic               p_dwe,
    output logic [DATA_W-1:0]  p_data,
    input  logic [TAG_W-1:0]   line_tag,
    input  line_state_t        line_state,
    input  logic [DATA_W-1:0]  line_data
);

    fsm_t              cur_q, nxt;
    logic              req_write_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    bus_cmd_t          req_cmd_q, cmd_d;
    logic              resp_d;
    logic [DATA_W-1:0] rdata_d;
    logic [TAG_W-1:0]  req_tag;
    logic              hit, victim_dirty, conflict;

    assign req_tag = req_addr_q[ADDR_W-1:INDEX_W];
    assign p_idx   = req_addr_q[INDEX_W-1:0];

    // Lookup qualifiers for the latched request.
    always_comb begin
        hit          = (line_state != ST_I) && (line_tag == req_tag);
        victim_dirty = (line_state == ST_M) && (line_tag != req_tag);
        conflict     = snoop_active && (snoop_idx == p_idx);
    end

    // Next-state, array writes, bus drive and response decision.
    always_comb begin
        nxt         = cur_q;
        cmd_d       = req_cmd_q;
        p_we        = 1'b0;
        p_tag       = req_tag;
        p_state     = ST_I;
        p_dwe       = 1'b0;
        p_data      = req_wdata_q;
        resp_d      = 1'b0;
        rdata_d     = cpu_rdata;
        bus_req     = 1'b0;
        bus_cmd_o   = CMD_NONE;
        bus_addr_o  = req_addr_q;
        bus_wdata_o = line_data;
        cpu_ready   = 1'b0;
        unique case (cur_q)
            F_IDLE: begin
                cpu_ready = 1'b1;
                if (cpu_valid) nxt = F_LOOKUP;
            end
            F_LOOKUP: begin
                if (!conflict) begin
                    if (hit && !req_write_q) begin
                        resp_d  = 1'b1;
                        rdata_d = line_data;
                        nxt     = F_IDLE;
                    end else if (hit && line_state == ST_M) begin
                        p_dwe   = 1'b1;
                        resp_d  = 1'b1;
                        rdata_d = req_wdata_q;
                        nxt     = F_IDLE;
                    end else begin
                        cmd_d = req_write_q ? CMD_RDX : CMD_RD;
                        nxt   = victim_dirty ? F_WBREQ : F_BUSREQ;
                    end
                end
            end
            F_WBREQ: begin
                if (line_state != ST_M) begin
                    nxt = F_BUSREQ;
                end else begin
                    bus_req    = 1'b1;
                    bus_cmd_o  = CMD_WB;
                    bus_addr_o = {line_tag, p_idx};
                    if (bus_gnt) begin
                        p_we    = 1'b1;
                        p_tag   = line_tag;
                        p_state = ST_I;
                        nxt     = F_BUSREQ;
                    end
                end
            end
            F_BUSREQ: begin
                bus_req   = 1'b1;
                bus_cmd_o = req_cmd_q;
                if (bus_gnt) nxt = F_WAIT;
            end
            F_WAIT: begin
                if (bus_rvalid) begin
                    p_we    = 1'b1;
                    p_state = req_write_q ? ST_M : ST_S;
                    p_dwe   = 1'b1;
                    p_data  = req_write_q ? req_wdata_q : bus_rdata;
                    resp_d  = 1'b1;
                    rdata_d = req_write_q ? req_wdata_q : bus_rdata;
                    nxt     = F_IDLE;
                end
            end
            default: nxt = F_IDLE;
        endcase
    end

    // State, request capture and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= F_IDLE;
            req_write_q <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            req_cmd_q   <= CMD_NONE;
            cpu_resp    <= 1'b0;
            cpu_rdata   <= '0;
        end else begin
            cur_q     <= nxt;
            req_cmd_q <= cmd_d;
            cpu_resp  <= resp_d;
            cpu_rdata <= rdata_d;
            if (cur_q == F_IDLE && cpu_valid) begin
                req_write_q <= cpu_write;
                req_addr_q  <= cpu_addr;
                req_wdata_q <= cpu_wdata;
            end
        end
    end

endmodule

// File: rtl/msi_cache_ctrl.sv
// Module: top of the MSI cache controller. Joins the line store, the snooper and the
// processor-side controller. Assumes an atomic, ordered broadcast bus whose arbiter
// mirrors the owner's command, address and identifier onto the shared bus inputs.
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int LINES    = 4,
    parameter int ID_W     = 2,
    parameter int CACHE_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_resp,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_valid,
    input  logic [1:0]        bus_cmd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ID_W-1:0]   bus_owner,
    input  logic              bus_rvalid,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data
);

    localparam int INDEX_W = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - INDEX_W;

    logic [INDEX_W-1:0] p_idx, s_idx;
    logic               p_we, p_dwe, s_we, snoop_active;
    logic [TAG_W-1:0]   p_tag, p_tag_q, s_tag_q;
    line_state_t        p_state, p_state_q, s_state, s_state_q;
    logic [DATA_W-1:0]  p_data, p_data_q, s_data_q;

    msi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .p_idx(p_idx), .p_we(p_we), .p_tag(p_tag), .p_state(p_state),
        .p_dwe(p_dwe), .p_data(p_data),
        .p_tag_q(p_tag_q), .p_state_q(p_state_q), .p_data_q(p_data_q),
        .s_idx(s_idx), .s_we(s_we), .s_state(s_state),
        .s_tag_q(s_tag_q), .s_state_q(s_state_q), .s_data_q(s_data_q)
    );

    msi_snoop_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES),
                     .ID_W(ID_W), .CACHE_ID(CACHE_ID)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_owner(bus_owner),
        .line_tag(s_tag_q), .line_state(s_state_q), .line_data(s_data_q),
        .s_idx(s_idx), .s_we(s_we), .s_state(s_state), .snoop_active(snoop_active),
        .snp_flush(snp_flush), .snp_data(snp_data)
    );

    msi_proc_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_resp(cpu_resp),
        .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_o(bus_cmd_o),
        .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .snoop_active(snoop_active), .snoop_idx(s_idx),
        .p_idx(p_idx), .p_we(p_we), .p_tag(p_tag), .p_state(p_state),
        .p_dwe(p_dwe), .p_data(p_data),
        .line_tag(p_tag_q), .line_state(p_state_q), .line_data(p_data_q)
    );

endmodule

// File: rtl/msi_cache_ctrl_chk.sv
// Module: protocol checker for msi_cache_ctrl, attached by bind.
// Assumes the shared bus inputs are driven to known values from reset.
module msi_cache_ctrl_chk #(
    parameter int ADDR_W   = 8,
    parameter int ID_W     = 2,
    parameter int CACHE_ID = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              cpu_resp,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              bus_valid,
    input logic [1:0]        bus_cmd,
    input logic [ID_W-1:0]   bus_owner,
    input logic              snp_flush
);

    // R5 / R7: a flush only follows a foreign read or read-exclusive cycle.
    p_flush_foreign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> $past(bus_valid && bus_owner != ID_W'(CACHE_ID)
                            && (bus_cmd == 2'd1 || bus_cmd == 2'd2)));

    // R8: a cycle owned by this cache never produces a flush.
    p_own_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_owner == ID_W'(CACHE_ID)) |=> !snp_flush);

    // R12: a read or read-exclusive request is held unchanged until granted.
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && bus_cmd_o != 2'd3)
        |=> (bus_req && $stable(bus_cmd_o) && $stable(bus_addr_o)));

    // R12: no command is driven without a request.
    p_idle_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> bus_cmd_o == 2'd0);

    // R10: the processor is held off while the bus is being requested.
    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_ready);

    // R10: the completion is a single-cycle pulse.
    p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp |=> !cpu_resp);

endmodule

bind msi_cache_ctrl msi_cache_ctrl_chk #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .CACHE_ID(CACHE_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_resp(cpu_resp),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o),
    .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_owner(bus_owner), .snp_flush(snp_flush)
);

// File: tb/msi_cache_ctrl_bench.sv
// Bench: models the bus arbiter, memory and a foreign cache; a scoreboard FIFO holds
// expected processor responses, which a monitor pops and compares.
module msi_cache_ctrl_bench;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int IW = 2;
    localparam logic [IW-1:0] MY_ID    = 2'd0;
    localparam logic [IW-1:0] OTHER_ID = 2'd1;
    localparam logic [1:0] C_NONE = 2'd0, C_RD = 2'd1, C_RDX = 2'd2, C_WB = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready, cpu_resp;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [1:0]    bus_cmd_o;
    logic [AW-1:0] bus_addr_o;
    logic [DW-1:0] bus_wdata_o;
    logic          bus_valid = 1'b0;
    logic [1:0]    bus_cmd = C_NONE;
    logic [AW-1:0] bus_addr = '0;
    logic [IW-1:0] bus_owner = OTHER_ID;
    logic          bus_rvalid = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_flush;
    logic [DW-1:0] snp_data;

    always #2 clk = ~clk;

    msi_cache_ctrl u_msi_cache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_resp(cpu_resp),
        .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_o(bus_cmd_o),
        .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_owner(bus_owner), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .snp_flush(snp_flush), .snp_data(snp_data)
    );

    logic [DW-1:0] mem [256];
    int checks = 0, fails = 0;
    int m_checks = 0, m_fails = 0;
    int resp_count = 0;
    bit done = 1'b0;

    // Scoreboard FIFO: written by the driver, read by the monitor.
    logic [DW-1:0] exp_q   [64];
    string         exp_tag [64];
    int wr_ptr = 0, rd_ptr = 0;

    function automatic logic [DW-1:0] init_word(input int a);
        return DW'(16'h1000 + a * 7);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected results as responses appear.
    logic prev_resp = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cpu_resp) begin
                m_checks++;
                if (rd_ptr == wr_ptr) begin
                    m_fails++;
                    $display("FAIL R10 unexpected response actual=%0h expected=none", cpu_rdata);
                end else begin
                    if (cpu_rdata !== exp_q[rd_ptr]) begin
                        m_fails++;
                        $display("FAIL %s data actual=%0h expected=%0h",
                                 exp_tag[rd_ptr], cpu_rdata, exp_q[rd_ptr]);
                    end
                    rd_ptr++;
                end
                resp_count++;
                if (prev_resp) begin
                    m_checks++;
                    m_fails++;
                    $display("FAIL R10 resp width actual=2 expected=1");
                end
            end
            prev_resp = cpu_resp;
        end
    end

    // Serve one transaction of the cache: hold a cycle, grant, then return data.
    task automatic serve_bus(output logic [1:0] c, output logic [AW-1:0] a);
        logic [DW-1:0] wd;
        c = bus_cmd_o;
        a = bus_addr_o;
        @(negedge clk);
        check(bus_req && bus_cmd_o == c && bus_addr_o == a, "R12 hold", int'(bus_cmd_o), int'(c));
        bus_gnt = 1'b1; bus_valid = 1'b1; bus_owner = MY_ID; bus_cmd = c; bus_addr = a;
        wd = bus_wdata_o;
        @(negedge clk);
        bus_gnt = 1'b0; bus_valid = 1'b0; bus_cmd = C_NONE; bus_owner = OTHER_ID;
        if (c == C_WB) begin
            mem[a] = wd;
        end else begin
            check(!snp_flush, "R8 own cycle", int'(snp_flush), 0);
            @(negedge clk);
            bus_rvalid = 1'b1; bus_rdata = mem[a];
            @(negedge clk);
            bus_rvalid = 1'b0;
        end
    endtask

    // Wait for the response while serving and recording bus requests.
    task automatic run_to_resp(input int start, input int n_exp,
                               input logic [1:0] c0, input logic [AW-1:0] a0,
                               input logic [1:0] c1, input logic [AW-1:0] a1,
                               input string req);
        int n = 0;
        logic [1:0] c;
        logic [AW-1:0] a;
        for (int cyc = 0; cyc < 100 && resp_count == start; cyc++) begin
            if (bus_req) begin
                serve_bus(c, a);
                if (n == 0) check(c == c0 && a == a0, req, int'({c, a}), int'({c0, a0}));
                if (n == 1) check(c == c1 && a == a1, req, int'({c, a}), int'({c1, a1}));
                n++;
            end else begin
                @(negedge clk);
            end
        end
        check(n == n_exp, req, n, n_exp);
    endtask

    // Driver: push the expected result, present the request, then run it out.
    task automatic cpu_op(input bit wr, input logic [AW-1:0] addr, input logic [DW-1:0] wdata,
                          input logic [DW-1:0] exp, input int n_exp,
                          input logic [1:0] c0, input logic [AW-1:0] a0,
                          input logic [1:0] c1, input logic [AW-1:0] a1, input string req);
        int start = resp_count;
        exp_q[wr_ptr] = exp; exp_tag[wr_ptr] = req; wr_ptr++;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = addr; cpu_wdata = wdata;
        @(negedge clk);
        cpu_valid = 1'b0;
        check(!cpu_ready, "R10 busy", int'(cpu_ready), 0);
        run_to_resp(start, n_exp, c0, a0, c1, a1, req);
    endtask

    // A cycle from another bus owner; the flush is judged one cycle later.
    task automatic snoop(input logic [IW-1:0] own, input logic [1:0] c, input logic [AW-1:0] a,
                         input bit exp_flush, input logic [DW-1:0] exp_data, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_owner = own; bus_cmd = c; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0; bus_cmd = C_NONE; bus_owner = OTHER_ID;
        check(snp_flush == exp_flush, req, int'(snp_flush), int'(exp_flush));
        if (exp_flush) begin
            check(snp_data == exp_data, req, int'(snp_data), int'(exp_data));
            mem[a] = snp_data;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks + m_checks + 1, fails + m_fails + 1);
            $finish;
        end
    end

    initial begin
        int start;
        for (int i = 0; i < 256; i++) mem[i] = init_word(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet reset state
        check(cpu_ready && !bus_req && !cpu_resp && !snp_flush && bus_cmd_o == C_NONE,
              "R1 reset", int'({cpu_ready, bus_req, cpu_resp, snp_flush}), 8);

        // R1, R2: first read misses, becomes Shared
        cpu_op(0, 8'h10, '0, init_word(8'h10), 1, C_RD, 8'h10, C_NONE, '0, "R2 read miss");
        // R3: Shared read hit
        cpu_op(0, 8'h10, '0, init_word(8'h10), 0, C_NONE, '0, C_NONE, '0, "R3 S hit");
        // R4: write to Shared needs read-exclusive
        cpu_op(1, 8'h10, 16'hA0A0, 16'hA0A0, 1, C_RDX, 8'h10, C_NONE, '0, "R4 S write");
        // R4: write to Modified stays local; R3 Modified read hit
        cpu_op(1, 8'h10, 16'hB0B0, 16'hB0B0, 0, C_NONE, '0, C_NONE, '0, "R4 M write");
        cpu_op(0, 8'h10, '0, 16'hB0B0, 0, C_NONE, '0, C_NONE, '0, "R3 M hit");

        // R5: foreign read on Modified flushes and downgrades
        snoop(OTHER_ID, C_RD, 8'h10, 1, 16'hB0B0, "R5 flush");
        cpu_op(0, 8'h10, '0, 16'hB0B0, 0, C_NONE, '0, C_NONE, '0, "R5 now S hit");
        cpu_op(1, 8'h10, 16'hC0C0, 16'hC0C0, 1, C_RDX, 8'h10, C_NONE, '0, "R5 S needs RDX");

        // R7: foreign read-exclusive on Modified flushes and invalidates
        snoop(OTHER_ID, C_RDX, 8'h10, 1, 16'hC0C0, "R7 M flush");
        cpu_op(0, 8'h10, '0, 16'hC0C0, 1, C_RD, 8'h10, C_NONE, '0, "R7 M invalidated");

        // R6: foreign read on Shared is silent; R7: read-exclusive on Shared invalidates
        snoop(OTHER_ID, C_RD, 8'h10, 0, '0, "R6 no flush");
        cpu_op(0, 8'h10, '0, 16'hC0C0, 0, C_NONE, '0, C_NONE, '0, "R6 stays S");
        snoop(OTHER_ID, C_RDX, 8'h10, 0, '0, "R7 S no flush");
        cpu_op(0, 8'h10, '0, 16'hC0C0, 1, C_RD, 8'h10, C_NONE, '0, "R7 S invalidated");

        // R8: a cycle carrying the own identifier is ignored
        cpu_op(1, 8'h21, 16'hD0D0, 16'hD0D0, 1, C_RDX, 8'h21, C_NONE, '0, "R4 I write");
        snoop(MY_ID, C_RDX, 8'h21, 0, '0, "R8 no flush");
        cpu_op(0, 8'h21, '0, 16'hD0D0, 0, C_NONE, '0, C_NONE, '0, "R8 still M");

        // R9: dirty victim written back first; clean victim dropped
        cpu_op(0, 8'h25, '0, init_word(8'h25), 2, C_WB, 8'h21, C_RD, 8'h25, "R9 dirty victim");
        check(mem[8'h21] == 16'hD0D0, "R9 wb data", int'(mem[8'h21]), 16'hD0D0);
        cpu_op(0, 8'h29, '0, init_word(8'h29), 1, C_RD, 8'h29, C_NONE, '0, "R9 clean victim");

        // R11: foreign read-exclusive in the lookup cycle of a Modified write
        cpu_op(1, 8'h32, 16'hE0E0, 16'hE0E0, 1, C_RDX, 8'h32, C_NONE, '0, "R4 I write");
        start = resp_count;
        exp_q[wr_ptr] = 16'hF0F0; exp_tag[wr_ptr] = "R11 retried write"; wr_ptr++;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = 8'h32; cpu_wdata = 16'hF0F0;
        @(negedge clk);
        cpu_valid = 1'b0;
        bus_valid = 1'b1; bus_owner = OTHER_ID; bus_cmd = C_RDX; bus_addr = 8'h32;
        @(negedge clk);
        bus_valid = 1'b0; bus_cmd = C_NONE;
        check(snp_flush && snp_data == 16'hE0E0, "R11 snoop first", int'(snp_data), 16'hE0E0);
        mem[8'h32] = snp_data;
        run_to_resp(start, 1, C_RDX, 8'h32, C_NONE, '0, "R11 retried write");
        cpu_op(0, 8'h32, '0, 16'hF0F0, 0, C_NONE, '0, C_NONE, '0, "R11 final M");

        repeat (3) @(negedge clk);
        check(rd_ptr == wr_ptr, "R10 all responses", rd_ptr, wr_ptr);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks + m_checks, fails + m_fails);
        $finish;
    end

endmodule